// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block recovers asynchronous serial characters from a line that has already been brought into the clock domain. A baud-rate tick that pulses sixteen times per bit period drives it. While the line is idle it waits for a falling edge. It confirms the start bit at mid-bit, then takes in eight or nine data bits least significant first and an optional parity bit. It then checks the stop position. The stop position can be one bit, one and a half bits or two bits long. Each bit is decided by a three-sample majority vote near its centre.

Each completed character is placed in a receive data register, and a set of sticky flags records what happened. The flags report data ready, framing error, noise, overrun, parity error, break and idle line. Software clears the data-ready flag with a data-register read strobe. The error and idle flags clear only when a status-register read strobe comes first and a data-register read strobe follows it. Three interrupt request lines are formed from the flags and their enable inputs: data, idle and error.

Top module: `osr_uart_rx`

## Requirements
- R1: Data bits are assembled least significant bit first. With `nine_bit_i`=0 eight bits are received and `rx_data_o[8]` reads 0. With `nine_bit_i`=1 nine bits are received.
- R2: After a falling edge on an idle line, the start bit is confirmed only if the majority of oversample points 8, 9 and 10 are low. Otherwise the receiver drops back to idle and produces no character.
- R3: Each bit takes the majority of its three samples (points 8, 9 and 10; points 16, 17 and 18 for the 1.5-stop position). Any disagreement among those three samples sets `ne_o` for the character. A disturbance at any other point has no effect.
- R4: With `stop_mode_i`=2'b00 (one stop bit), the stop bit is sampled at points 8 to 10, and `rdy_o` rises after the 16th tick of the stop bit.
- R5: With `stop_mode_i`=2'b10 or 2'b11 (two stop bits), only the first stop bit is checked, and `rdy_o` rises after its 16th tick. A low line during the second stop bit causes no framing error and does not start a character.
- R6: With `stop_mode_i`=2'b01 (1.5 stop bits), ticks 1 to 8 of the stop position are ignored. The stop value comes from points 16 to 18, and `rdy_o` and `fe_o` update together after tick 24.
- R7: A low stop sample sets `fe_o`, and the received data is still loaded into `rx_data_o`.
- R8: A character whose start, data, parity and stop samples are all low sets both `brk_o` and `fe_o`.
- R9: With `parity_en_i`=1, one parity bit follows the data. `parity_odd_i`=0 requires an even number of ones over data and parity, and 1 requires an odd number. A mismatch sets `pe_o`.
- R10: If a character completes while `rdy_o` is set and no data read occurs in that cycle, `ore_o` is set and `rx_data_o` keeps its old value.
- R11: A `rd_data_i` strobe clears `rdy_o`. `fe_o`, `ne_o`, `ore_o`, `pe_o`, `brk_o` and `idle_o` clear only on a `rd_data_i` strobe that comes after a `rd_status_i` strobe with no data read in between.
- R12: After at least one character has been received, `idle_o` sets once the line has stayed high for one frame time. One frame time is 16 ticks times (10 + `nine_bit_i` + `parity_en_i`). The flag does not set again until another character is received.
- R13: Deasserting `rx_en_i` in the middle of a character discards that character.
- R14: `irq_data_o` is `ie_data_i` AND `rdy_o`, and `irq_idle_o` is `ie_idle_i` AND `idle_o`. `irq_err_o` is raised for any of fe/ne/ore/pe only when both `ie_err_i` and `multi_buf_i` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Synchronized serial line |
| os_tick_i | input | 1 | Oversample tick, 16 per bit |
| rx_en_i | input | 1 | Receiver enable |
| nine_bit_i | input | 1 | 1: nine data bits, 0: eight |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1: odd parity, 0: even |
| stop_mode_i | input | 2 | 00 one, 01 one and a half, 1x two stop bits |
| multi_buf_i | input | 1 | Multi-buffer mode, enables the separate error interrupt |
| ie_data_i | input | 1 | Data-ready interrupt enable |
| ie_idle_i | input | 1 | Idle interrupt enable |
| ie_err_i | input | 1 | Error interrupt enable |
| rd_status_i | input | 1 | Status register read strobe |
| rd_data_i | input | 1 | Data register read strobe |
| rx_data_o | output | 9 | Receive data register |
| rdy_o | output | 1 | Data ready |
| fe_o | output | 1 | Framing error |
| ne_o | output | 1 | Noise detected |
| ore_o | output | 1 | Overrun |
| pe_o | output | 1 | Parity error |
| brk_o | output | 1 | Break character |
| idle_o | output | 1 | Idle line detected |
| irq_data_o | output | 1 | Data interrupt request |
| irq_idle_o | output | 1 | Idle interrupt request |
| irq_err_o | output | 1 | Error interrupt request |

## Verification
The hardest situations to reach from the ports are the ones that depend on a single oversample point. These are a glitch that lands on one of the three voting samples, a stop level that changes inside the dead half bit of the 1.5-stop mode, and the exact tick on which data-ready rises. The bench drives the line one tick at a time, so it can flip a chosen point of a chosen bit. It then checks the flags one tick before and one tick after the expected edge. Idle detection is checked the same way, by counting high ticks to one short of the frame time and then to exactly the frame time.

// File: rtl/osr_uart_pkg.sv
package osr_uart_pkg;

    localparam int OS_RATE = 16;
    localparam int MID_PT  = OS_RATE / 2;
    localparam int DATA_W  = 9;
    localparam int POS_W   = $clog2(OS_RATE + MID_PT + 1);
    localparam int IDLE_W  = $clog2(OS_RATE * 12 + 1);
    localparam int BIT_W   = $clog2(DATA_W + 1);

    localparam logic [1:0] STOP_HALF_CODE = 2'b01;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fe;
        logic              ne;
        logic              pe;
        logic              brk;
    } frame_t;

    typedef struct packed {
        logic rdy;
        logic fe;
        logic ne;
        logic ore;
        logic pe;
        logic brk;
        logic idle;
    } flags_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/osr_bit_sampler.sv
module osr_bit_sampler
    import osr_uart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_i,
    input  logic rx_i,
    output logic vote_o,
    output logic noisy_o
);
    logic [2:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 3'b111;
        end else if (cap_i) begin
            samp_q <= {samp_q[1:0], rx_i};
        end
    end

    assign vote_o  = maj3(samp_q);
    assign noisy_o = (|samp_q) & ~(&samp_q);

endmodule

// File: rtl/osr_frame_fsm.sv
module osr_frame_fsm
    import osr_uart_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   rx_i,
    input  logic   en_i,
    input  logic   nine_i,
    input  logic   par_en_i,
    input  logic   par_odd_i,
    input  logic [1:0] stop_mode_i,
    output logic   commit_o,
    output frame_t frame_o,
    output logic   in_idle_o
);
    localparam logic [POS_W-1:0] P_ONE      = POS_W'(1);
    localparam logic [POS_W-1:0] P_MID      = POS_W'(MID_PT);
    localparam logic [POS_W-1:0] P_STARTCHK = POS_W'(MID_PT + 3);
    localparam logic [POS_W-1:0] P_BIT_END  = POS_W'(OS_RATE);
    localparam logic [POS_W-1:0] P_HALF_SMP = POS_W'(OS_RATE);
    localparam logic [POS_W-1:0] P_HALF_END = POS_W'(OS_RATE + MID_PT);

    rx_state_e          state_q;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   pos_nx;
    logic [BIT_W-1:0]   bit_q;
    logic [BIT_W-1:0]   last_bit;
    logic [DATA_W-1:0]  sh_q;
    logic [DATA_W-1:0]  data_sel;
    logic               ne_q;
    logic               zero_q;
    logic               pbit_q;
    logic               commit_q;
    frame_t             frame_q;
    logic               half_mode;
    logic [POS_W-1:0]   first_pt;
    logic [POS_W-1:0]   end_pt;
    logic               in_frame;
    logic               cap;
    logic               vote;
    logic               noisy;

    assign pos_nx    = pos_q + P_ONE;
    assign half_mode = (state_q == RX_STOP) && (stop_mode_i == STOP_HALF_CODE);
    assign first_pt  = half_mode ? P_HALF_SMP : P_MID;
    assign end_pt    = half_mode ? P_HALF_END : P_BIT_END;
    assign in_frame  = (state_q == RX_START) || (state_q == RX_DATA) ||
                       (state_q == RX_PAR)   || (state_q == RX_STOP);
    assign cap       = tick_i && en_i && in_frame &&
                       (pos_nx >= first_pt) && ((pos_nx - first_pt) < POS_W'(3));
    assign last_bit  = nine_i ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2);
    assign data_sel  = nine_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};

    osr_bit_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap),
        .rx_i    (rx_i),
        .vote_o  (vote),
        .noisy_o (noisy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_IDLE;
            pos_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            ne_q     <= 1'b0;
            zero_q   <= 1'b0;
            pbit_q   <= 1'b0;
            commit_q <= 1'b0;
            frame_q  <= '0;
        end else begin
            commit_q <= 1'b0;
            if (!en_i) begin
                state_q <= RX_IDLE;
                pos_q   <= '0;
            end else if (tick_i) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!rx_i) begin
                            state_q <= RX_START;
                            pos_q   <= P_ONE;
                            bit_q   <= '0;
                            sh_q    <= '0;
                            ne_q    <= 1'b0;
                            zero_q  <= 1'b1;
                            pbit_q  <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (pos_nx == P_STARTCHK && vote) begin
                            state_q <= RX_IDLE;
                            pos_q   <= '0;
                        end else if (pos_nx == P_BIT_END) begin
                            state_q <= RX_DATA;
                            pos_q   <= '0;
                        end else begin
                            pos_q <= pos_nx;
                            if (pos_nx == P_STARTCHK) ne_q <= noisy;
                        end
                    end
                    RX_DATA: begin
                        if (pos_nx == P_BIT_END) begin
                            pos_q  <= '0;
                            sh_q   <= {vote, sh_q[DATA_W-1:1]};
                            ne_q   <= ne_q | noisy;
                            zero_q <= zero_q & ~vote;
                            bit_q  <= bit_q + BIT_W'(1);
                            if (bit_q == last_bit)
                                state_q <= par_en_i ? RX_PAR : RX_STOP;
                        end else begin
                            pos_q <= pos_nx;
                        end
                    end
                    RX_PAR: begin
                        if (pos_nx == P_BIT_END) begin
                            pos_q   <= '0;
                            pbit_q  <= vote;
                            ne_q    <= ne_q | noisy;
                            zero_q  <= zero_q & ~vote;
                            state_q <= RX_STOP;
                        end else begin
                            pos_q <= pos_nx;
                        end
                    end
                    RX_STOP: begin
                        if (pos_nx == end_pt) begin
                            pos_q         <= '0;
                            commit_q      <= 1'b1;
                            frame_q.data  <= data_sel;
                            frame_q.fe    <= ~vote;
                            frame_q.ne    <= ne_q | noisy;
                            frame_q.pe    <= par_en_i & parity_bad(data_sel, pbit_q, par_odd_i);
                            frame_q.brk   <= ~vote & zero_q;
                            state_q       <= stop_mode_i[1] ? RX_STOP2 : RX_IDLE;
                        end else begin
                            pos_q <= pos_nx;
                        end
                    end
                    RX_STOP2: begin
                        if (pos_nx == P_BIT_END) begin
                            pos_q   <= '0;
                            state_q <= RX_IDLE;
                        end else begin
                            pos_q <= pos_nx;
                        end
                    end
                    default: begin
                        state_q <= RX_IDLE;
                        pos_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign commit_o  = commit_q;
    assign frame_o   = frame_q;
    assign in_idle_o = (state_q == RX_IDLE);

    // A character is only ever completed on an oversample tick (R4)
    assert_commit_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> $past(tick_i));

    // A break character always carries a framing error (R8)
    assert_break_is_fe_R8: assert property (@(posedge clk) disable iff (rst)
        (commit_q && frame_q.brk) |-> frame_q.fe);

    // Dropping the enable abandons any character in progress (R13)
    assert_disable_discards_R13: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !in_idle_o) |=> (in_idle_o && !commit_q));

endmodule

// File: rtl/osr_idle_watch.sv
module osr_idle_watch
    import osr_uart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rx_i,
    input  logic en_i,
    input  logic in_idle_i,
    input  logic commit_i,
    input  logic nine_i,
    input  logic par_en_i,
    output logic idle_set_o
);
    logic [IDLE_W-1:0] cnt_q;
    logic [IDLE_W-1:0] flen;
    logic              armed_q;
    logic              set_q;

    assign flen = IDLE_W'(OS_RATE * 10)
                + (nine_i   ? IDLE_W'(OS_RATE) : '0)
                + (par_en_i ? IDLE_W'(OS_RATE) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            set_q <= 1'b0;
            if (commit_i) armed_q <= 1'b1;
            if (!en_i || !in_idle_i || !rx_i) begin
                cnt_q <= '0;
            end else if (tick_i && armed_q) begin
                if (cnt_q == flen - IDLE_W'(1)) begin
                    set_q   <= 1'b1;
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + IDLE_W'(1);
                end
            end
        end
    end

    assign idle_set_o = set_q;

    // Idle is reported once per received character, never twice in a row (R12)
    assert_idle_single_R12: assert property (@(posedge clk) disable iff (rst)
        set_q |=> !set_q);

endmodule

// File: rtl/osr_status_regs.sv
module osr_status_regs
    import osr_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  frame_t            frame_i,
    input  logic              idle_set_i,
    input  logic              rd_status_i,
    input  logic              rd_data_i,
    output logic [DATA_W-1:0] data_o,
    output flags_t            flags_o
);
    flags_t            flags_q;
    flags_t            flags_nx;
    logic [DATA_W-1:0] data_q;
    logic              armed_q;
    logic              load;
    logic              ovr;
    logic              clr_err;

    assign load    = commit_i && !(flags_q.rdy && !rd_data_i);
    assign ovr     = commit_i &&  (flags_q.rdy && !rd_data_i);
    assign clr_err = rd_data_i && armed_q;

    always_comb begin
        flags_nx = flags_q;
        if (rd_data_i) flags_nx.rdy = 1'b0;
        if (clr_err) begin
            flags_nx.fe   = 1'b0;
            flags_nx.ne   = 1'b0;
            flags_nx.ore  = 1'b0;
            flags_nx.pe   = 1'b0;
            flags_nx.brk  = 1'b0;
            flags_nx.idle = 1'b0;
        end
        if (load) begin
            flags_nx.rdy = 1'b1;
            flags_nx.fe  = flags_nx.fe  | frame_i.fe;
            flags_nx.ne  = flags_nx.ne  | frame_i.ne;
            flags_nx.pe  = flags_nx.pe  | frame_i.pe;
            flags_nx.brk = flags_nx.brk | frame_i.brk;
        end
        if (ovr)        flags_nx.ore  = 1'b1;
        if (idle_set_i) flags_nx.idle = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            data_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            flags_q <= flags_nx;
            if (load) data_q <= frame_i.data;
            if (rd_status_i)    armed_q <= 1'b1;
            else if (rd_data_i) armed_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign flags_o = flags_q;

    // Overrun keeps the previous character and raises the overrun flag (R10)
    assert_ovr_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (commit_i && flags_q.rdy && !rd_data_i) |=> (flags_q.ore && $stable(data_q)));

    // A data read not preceded by a status read leaves the sticky flags alone (R11)
    assert_err_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_data_i && !armed_q && !commit_i && !idle_set_i)
        |=> $stable({flags_q.fe, flags_q.ne, flags_q.ore, flags_q.pe, flags_q.brk, flags_q.idle}));

    // A data read with nothing arriving drops data-ready (R11)
    assert_rd_clears_rdy_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_data_i && !commit_i) |=> !flags_q.rdy);

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       os_tick_i,
    input  logic       rx_en_i,
    input  logic       nine_bit_i,
    input  logic       parity_en_i,
    input  logic       parity_odd_i,
    input  logic [1:0] stop_mode_i,
    input  logic       multi_buf_i,
    input  logic       ie_data_i,
    input  logic       ie_idle_i,
    input  logic       ie_err_i,
    input  logic       rd_status_i,
    input  logic       rd_data_i,
    output logic [8:0] rx_data_o,
    output logic       rdy_o,
    output logic       fe_o,
    output logic       ne_o,
    output logic       ore_o,
    output logic       pe_o,
    output logic       brk_o,
    output logic       idle_o,
    output logic       irq_data_o,
    output logic       irq_idle_o,
    output logic       irq_err_o
);
    logic   commit;
    frame_t frame;
    logic   in_idle;
    logic   idle_set;
    flags_t flags;

    osr_frame_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (os_tick_i),
        .rx_i        (rx_i),
        .en_i        (rx_en_i),
        .nine_i      (nine_bit_i),
        .par_en_i    (parity_en_i),
        .par_odd_i   (parity_odd_i),
        .stop_mode_i (stop_mode_i),
        .commit_o    (commit),
        .frame_o     (frame),
        .in_idle_o   (in_idle)
    );

    osr_idle_watch u_idle (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (os_tick_i),
        .rx_i       (rx_i),
        .en_i       (rx_en_i),
        .in_idle_i  (in_idle),
        .commit_i   (commit),
        .nine_i     (nine_bit_i),
        .par_en_i   (parity_en_i),
        .idle_set_o (idle_set)
    );

    osr_status_regs u_stat (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .frame_i     (frame),
        .idle_set_i  (idle_set),
        .rd_status_i (rd_status_i),
        .rd_data_i   (rd_data_i),
        .data_o      (rx_data_o),
        .flags_o     (flags)
    );

    assign rdy_o  = flags.rdy;
    assign fe_o   = flags.fe;
    assign ne_o   = flags.ne;
    assign ore_o  = flags.ore;
    assign pe_o   = flags.pe;
    assign brk_o  = flags.brk;
    assign idle_o = flags.idle;

    assign irq_data_o = ie_data_i & flags.rdy;
    assign irq_idle_o = ie_idle_i & flags.idle;
    assign irq_err_o  = ie_err_i & multi_buf_i &
                        (flags.fe | flags.ne | flags.ore | flags.pe);

endmodule

// File: tb/osr_uart_rx_bench.sv
module osr_uart_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       en = 1'b1;
    logic       nine = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_mode = 2'b00;
    logic       multi = 1'b0;
    logic       ie_data = 1'b0;
    logic       ie_idle = 1'b0;
    logic       ie_err = 1'b0;
    logic       rd_stat = 1'b0;
    logic       rd_dat = 1'b0;
    logic [8:0] dout;
    logic       rdy, fe, ne, ore, pe, brk, idle;
    logic       irq_d, irq_i, irq_e;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osr_uart_rx u_osr_uart_rx (
        .clk (clk), .rst (rst), .rx_i (rx), .os_tick_i (tick), .rx_en_i (en),
        .nine_bit_i (nine), .parity_en_i (par_en), .parity_odd_i (par_odd),
        .stop_mode_i (stop_mode), .multi_buf_i (multi), .ie_data_i (ie_data),
        .ie_idle_i (ie_idle), .ie_err_i (ie_err), .rd_status_i (rd_stat),
        .rd_data_i (rd_dat), .rx_data_o (dout), .rdy_o (rdy), .fe_o (fe),
        .ne_o (ne), .ore_o (ore), .pe_o (pe), .brk_o (brk), .idle_o (idle),
        .irq_data_o (irq_d), .irq_idle_o (irq_i), .irq_err_o (irq_e)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_once(input logic v);
        @(negedge clk);
        rx   = v;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        repeat (16) tick_once(v);
    endtask

    task automatic send_bit_glitch(input logic v, input int gp);
        for (int i = 1; i <= 16; i++) tick_once(i == gp ? ~v : v);
    endtask

    task automatic high_ticks(input int n);
        repeat (n) tick_once(1'b1);
    endtask

    // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
    task automatic send_head(input logic [8:0] d, input int nb, input int pmode,
                             input int gbit, input int gpt);
        logic p;
        p = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            p = p ^ d[i];
            if (i == gbit) send_bit_glitch(d[i], gpt);
            else           send_bit(d[i]);
        end
        if (pmode != 0) begin
            if (par_odd)    p = ~p;
            if (pmode == 2) p = ~p;
            send_bit(p);
        end
    endtask

    task automatic rd_status_pulse();
        @(negedge clk); rd_stat = 1'b1;
        @(negedge clk); rd_stat = 1'b0;
    endtask

    task automatic rd_data_pulse();
        @(negedge clk); rd_dat = 1'b1;
        @(negedge clk); rd_dat = 1'b0;
    endtask

    task automatic clear_all();
        rd_status_pulse();
        rd_data_pulse();
    endtask

    task automatic t_reset();
        chk("R11 reset rdy", rdy, 0);
        chk("R11 reset flags", {fe, ne, ore, pe, brk, idle}, 0);
        chk("R1 reset data", dout, 0);
        high_ticks(300);
        chk("R12 no idle before any character", idle, 0);
    endtask

    task automatic t_basic();
        ie_data = 1'b1;
        send_head(9'h0A5, 8, 0, -1, 0);
        repeat (15) tick_once(1'b1);
        chk("R4 rdy low before stop tick 16", rdy, 0);
        tick_once(1'b1);
        chk("R4 rdy after stop tick 16", rdy, 1);
        chk("R1 eight-bit data lsb first", dout, 9'h0A5);
        chk("R7 no fe on good stop", fe, 0);
        chk("R14 data irq", irq_d, 1);
        clear_all();
        chk("R14 data irq after read", irq_d, 0);
        nine = 1'b1;
        send_head(9'h1A5, 9, 0, -1, 0);
        send_bit(1'b1);
        chk("R1 nine-bit data", dout, 9'h1A5);
        clear_all();
        nine = 1'b0;
    endtask

    task automatic t_noise();
        send_head(9'h0C3, 8, 0, 3, 9);
        send_bit(1'b1);
        chk("R3 majority data with glitch", dout, 9'h0C3);
        chk("R3 noise flagged", ne, 1);
        clear_all();
        send_head(9'h0C3, 8, 0, 3, 4);
        send_bit(1'b1);
        chk("R3 glitch off sample points ignored", ne, 0);
        clear_all();
    endtask

    task automatic t_false_start();
        repeat (5) tick_once(1'b0);
        high_ticks(30);
        chk("R2 false start gives no character", rdy, 0);
        send_head(9'h03C, 8, 0, -1, 0);
        send_bit(1'b1);
        chk("R2 receiver back to idle after false start", dout, 9'h03C);
        clear_all();
    endtask

    task automatic t_stop_two();
        stop_mode = 2'b10;
        send_head(9'h05A, 8, 0, -1, 0);
        send_bit(1'b1);
        chk("R5 rdy after first stop bit", rdy, 1);
        send_bit(1'b0);
        high_ticks(20);
        chk("R5 second stop not checked", fe, 0);
        chk("R5 low second stop starts no character", ore, 0);
        chk("R5 data", dout, 9'h05A);
        clear_all();
        stop_mode = 2'b00;
    endtask

    task automatic t_stop_half();
        stop_mode = 2'b01;
        send_head(9'h096, 8, 0, -1, 0);
        repeat (8)  tick_once(1'b0);
        repeat (15) tick_once(1'b1);
        chk("R6 rdy low at stop tick 23", rdy, 0);
        tick_once(1'b1);
        chk("R6 rdy at stop tick 24", rdy, 1);
        chk("R6 dead half bit ignored", fe, 0);
        clear_all();
        send_head(9'h011, 8, 0, -1, 0);
        repeat (15) tick_once(1'b1);
        repeat (3)  tick_once(1'b0);
        repeat (5)  tick_once(1'b1);
        chk("R6 no flags before tick 24", {rdy, fe}, 0);
        tick_once(1'b1);
        chk("R6 rdy and fe together", {rdy, fe}, 2'b11);
        chk("R7 data loaded on fe", dout, 9'h011);
        clear_all();
        stop_mode = 2'b00;
    endtask

    task automatic t_framing_clear();
        send_head(9'h077, 8, 0, -1, 0);
        send_bit(1'b0);
        high_ticks(2);
        chk("R7 fe set", fe, 1);
        chk("R7 invalid data still loaded", dout, 9'h077);
        chk("R8 not a break", brk, 0);
        rd_data_pulse();
        chk("R11 data read clears rdy", rdy, 0);
        chk("R11 fe survives lone data read", fe, 1);
        rd_status_pulse();
        chk("R11 status read alone keeps fe", fe, 1);
        rd_data_pulse();
        chk("R11 status then data clears fe", fe, 0);
    endtask

    task automatic t_break();
        send_head(9'h000, 8, 0, -1, 0);
        send_bit(1'b0);
        high_ticks(2);
        chk("R8 break sets brk and fe", {brk, fe}, 2'b11);
        chk("R8 break data", dout, 0);
        clear_all();
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        par_odd = 1'b0;
        send_head(9'h0B1, 8, 1, -1, 0);
        send_bit(1'b1);
        chk("R9 even parity good", pe, 0);
        chk("R9 data with parity", dout, 9'h0B1);
        clear_all();
        send_head(9'h0B1, 8, 2, -1, 0);
        send_bit(1'b1);
        chk("R9 even parity bad", pe, 1);
        clear_all();
        par_odd = 1'b1;
        send_head(9'h0B1, 8, 1, -1, 0);
        send_bit(1'b1);
        chk("R9 odd parity good", pe, 0);
        clear_all();
        par_en = 1'b0;
        par_odd = 1'b0;
    endtask

    task automatic t_overrun();
        send_head(9'h012, 8, 0, -1, 0);
        send_bit(1'b1);
        send_head(9'h034, 8, 0, -1, 0);
        send_bit(1'b1);
        chk("R10 overrun flag", ore, 1);
        chk("R10 old data kept", dout, 9'h012);
        clear_all();
        chk("R10 overrun cleared by sequence", {ore, rdy}, 0);
    endtask

    task automatic t_enable();
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        @(negedge clk); en = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        en = 1'b1;
        high_ticks(200);
        chk("R13 aborted character discarded", {rdy, fe}, 0);
        send_head(9'h042, 8, 0, -1, 0);
        send_bit(1'b1);
        chk("R13 next character after re-enable", dout, 9'h042);
        clear_all();
    endtask

    task automatic t_idle();
        ie_idle = 1'b1;
        clear_all();
        send_head(9'h081, 8, 0, -1, 0);
        send_bit(1'b1);
        clear_all();
        high_ticks(159);
        chk("R12 idle not yet at 159 ticks", idle, 0);
        high_ticks(1);
        chk("R12 idle at one frame time", idle, 1);
        chk("R14 idle irq", irq_i, 1);
        clear_all();
        high_ticks(200);
        chk("R12 idle does not re-arm", idle, 0);
        ie_idle = 1'b0;
    endtask

    task automatic t_irq();
        ie_data = 1'b1;
        ie_err = 1'b1;
        multi = 1'b0;
        send_head(9'h055, 8, 0, -1, 0);
        send_bit(1'b0);
        high_ticks(2);
        chk("R14 no error irq in single buffer", irq_e, 0);
        chk("R14 data irq with fe", irq_d, 1);
        @(negedge clk); multi = 1'b1;
        #1;
        chk("R14 error irq in multi buffer", irq_e, 1);
        ie_data = 1'b0;
        #1;
        chk("R14 data irq masked", irq_d, 0);
        clear_all();
        chk("R14 error irq gone after clear", irq_e, 0);
        multi = 1'b0;
        ie_err = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_noise();
        t_false_start();
        t_stop_two();
        t_stop_half();
        t_framing_clear();
        t_break();
        t_parity();
        t_overrun();
        t_enable();
        t_idle();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule